// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between a clocked host and an external 128K x 16 asynchronous static RAM. The host raises a request with a read/write flag, a 17-bit word address, 16 bits of write data and a 2-bit byte mask. The block turns each request into one RAM cycle with the right strobe shape and then pulses a done signal. The RAM has one active-low chip enable per byte lane, plus an active-low write strobe and an active-low output enable. The byte mask picks which lane enables go low. A lane whose enable stays high is never driven by the controller, and the RAM leaves it floating.

All RAM timing minimums are given in nanoseconds and turned into whole clock cycles by rounding up, against a clock period parameter. These minimums are the read cycle, the write pulse, the data setup and the write recovery. The default clock is 100 MHz. Each access window is followed by a quiet gap in which every RAM control is high. This gap gives the write recovery time and the bus turnaround after a read. The done pulse comes at the end of the gap.

The tristate data pins are modelled as a data input, a data output and one drive enable per byte lane.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, both chip enables, the write strobe and the output enable are high. Both lane drive enables are 0, and the done pulse and read data are 0.
- R2: A read holds the write strobe high and the output enable low for RD_LEN cycles (7 at default parameters). Read data is captured on the last cycle of that window. Mask bit 1 selects data bits 15:8 and mask bit 0 selects bits 7:0. A lane that was not selected returns 0.
- R3: A write holds the write strobe low and the output enable high for WP_LEN cycles. WP_LEN is the largest of the write-pulse count, the data-setup count, and the read-cycle count minus the gap (6 at default parameters). The write takes effect when the strobe rises.
- R4: The controller drives a byte lane only while the write strobe is low and that lane's chip enable is low. It never drives while the output enable is low.
- R5: Only the chip enables of selected lanes go low. The RAM address stays constant for as long as any chip enable is low.
- R6: Every access ends with a gap of GAP_LEN cycles (1 at default parameters) in which all RAM controls are high. The done pulse is high only in the first idle cycle after that gap.
- R7: The done pulse lasts one cycle. A request is accepted only while the block is idle and done is low. The number of clock edges from request to done is RD_LEN+GAP_LEN+1 for reads and WP_LEN+GAP_LEN+1 for writes, so it is never shorter than the read-cycle minimum.
- R8: A request whose byte mask is 0 asserts no RAM control and changes no RAM contents. It returns done after GAP_LEN+1 edges, and as a read it returns 0.
- R9: Read data keeps the result of the latest read until the next request is accepted, at which point it clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Host request, held until done |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| bmask_i | input | 2 | Byte mask, bit 1 upper lane, bit 0 lower lane |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read result |
| ram_addr_o | output | 17 | RAM address pins |
| ram_ceu_n_o | output | 1 | Upper-lane chip enable, active low |
| ram_cel_n_o | output | 1 | Lower-lane chip enable, active low |
| ram_we_n_o | output | 1 | Write strobe, active low |
| ram_oe_n_o | output | 1 | Output enable, active low |
| ram_dq_o | output | 16 | Data driven toward the RAM |
| ram_dq_oe_o | output | 2 | Drive enable per lane, bit 1 upper |
| ram_dq_i | input | 16 | Data returned from the RAM pins |

## Verification
The hardest case to reach from the ports is a write with one lane masked, followed by reads under every other mask. The bench has to show three things for that case. The untouched lane still holds its older byte. A lane that was not selected reads back as 0, even though the bus model drives a junk byte on it. No lane was driven while its enable was high.

The bench gets there by sweeping all four write masks against all four read masks at boundary and patterned addresses. A pin-level RAM model in the bench commits a byte only on the rising write strobe and only for lanes that were both enabled and driven. An arithmetic shadow copy supplies the expected words.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_GAP   = 2'd3
    } phase_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } lane_t;

    localparam int NUM_LANES = 2;

    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int bits_for(input int n);
        int w;
        w = 1;
        while ((1 << w) <= n) w++;
        return w;
    endfunction

endpackage

// File: rtl/sram_seq.sv
module sram_seq
    import sram_lane_pkg::*;
#(
    parameter int RD_LEN  = 7,
    parameter int WP_LEN  = 6,
    parameter int GAP_LEN = 1,
    localparam int CNT_W  = bits_for(imax(imax(RD_LEN, WP_LEN), GAP_LEN))
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_i,
    input  logic   wr_i,
    input  lane_t  mask_i,
    output phase_e phase_o,
    output logic   load_o,
    output logic   last_o,
    output logic   done_o
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;

    assign load_o  = (phase_q == PH_IDLE) && req_i && !done_o;
    assign last_o  = (cnt_q == '0);
    assign phase_o = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (load_o) begin
                        if (mask_i == '0) begin
                            phase_q <= PH_GAP;
                            cnt_q   <= CNT_W'(GAP_LEN - 1);
                        end else if (wr_i) begin
                            phase_q <= PH_WRITE;
                            cnt_q   <= CNT_W'(WP_LEN - 1);
                        end else begin
                            phase_q <= PH_READ;
                            cnt_q   <= CNT_W'(RD_LEN - 1);
                        end
                    end
                end
                PH_READ, PH_WRITE: begin
                    if (last_o) begin
                        phase_q <= PH_GAP;
                        cnt_q   <= CNT_W'(GAP_LEN - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_GAP: begin
                    if (last_o) begin
                        phase_q <= PH_IDLE;
                        done_o  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    done_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ($past(phase_q) == PH_GAP) && (phase_q == PH_IDLE));

    // R7
    no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE) |=> !$past(load_o));

endmodule

// File: rtl/sram_pins.sv
module sram_pins
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    localparam int LANE_W = DATA_W / NUM_LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  phase_e               phase_i,
    input  logic                 load_i,
    input  logic                 last_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  lane_t                mask_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic [ADDR_W-1:0]    ram_addr_o,
    output logic [NUM_LANES-1:0] ram_ce_n_o,
    output logic                 ram_we_n_o,
    output logic                 ram_oe_n_o,
    output logic [DATA_W-1:0]    ram_dq_o,
    output logic [NUM_LANES-1:0] ram_dq_oe_o,
    input  logic [DATA_W-1:0]    ram_dq_i
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        lane_t             lanes;
    } cmd_t;

    cmd_t              cmd_q;
    logic              active;
    logic [DATA_W-1:0] cap_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (load_i) begin
            cmd_q <= '{addr: addr_i, data: wdata_i, lanes: mask_i};
        end
    end

    assign active     = (phase_i == PH_READ) || (phase_i == PH_WRITE);
    assign ram_we_n_o = (phase_i != PH_WRITE);
    assign ram_oe_n_o = (phase_i != PH_READ);
    assign ram_addr_o = cmd_q.addr;
    assign ram_dq_o   = cmd_q.data;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic sel;
        assign sel            = (g == 0) ? cmd_q.lanes.lo : cmd_q.lanes.hi;
        assign ram_ce_n_o[g]  = !(active && sel);
        assign ram_dq_oe_o[g] = (phase_i == PH_WRITE) && sel;
        assign cap_val[g*LANE_W +: LANE_W] = sel ? ram_dq_i[g*LANE_W +: LANE_W] : '0;

        // R4
        lane_drive_chk: assert property (@(posedge clk) disable iff (rst)
            ram_dq_oe_o[g] |-> !ram_ce_n_o[g] && !ram_we_n_o);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
        end else if (load_i) begin
            rdata_o <= '0;
        end else if ((phase_i == PH_READ) && last_i) begin
            rdata_o <= cap_val;
        end
    end

    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n_o |-> (ram_dq_oe_o == '0) && ram_we_n_o);

    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(&ram_ce_n_o) && !(&$past(ram_ce_n_o))) |-> $stable(ram_addr_o));

    // R8
    empty_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.lanes == '0) |-> (&ram_ce_n_o) && ram_we_n_o && ram_oe_n_o);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 16,
    parameter int CLK_NS = 10,
    parameter int RC_NS  = 70,
    parameter int WP_NS  = 55,
    parameter int DS_NS  = 30,
    parameter int WR_NS  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [1:0]        bmask_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic              ram_ceu_n_o,
    output logic              ram_cel_n_o,
    output logic              ram_we_n_o,
    output logic              ram_oe_n_o,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic [1:0]        ram_dq_oe_o,
    input  logic [DATA_W-1:0] ram_dq_i
);

    localparam int RC_C    = ns2cyc(RC_NS, CLK_NS);
    localparam int WP_C    = ns2cyc(WP_NS, CLK_NS);
    localparam int DS_C    = ns2cyc(DS_NS, CLK_NS);
    localparam int WR_C    = ns2cyc(WR_NS, CLK_NS);
    localparam int GAP_LEN = imax(WR_C, 1);
    localparam int RD_LEN  = imax(RC_C, 1);
    localparam int WP_LEN  = imax(imax(WP_C, DS_C), imax(RC_C - GAP_LEN, 1));

    phase_e           phase;
    logic             load;
    logic             last;
    lane_t            mask;
    logic [1:0]       ce_n;

    assign mask        = lane_t'(bmask_i);
    assign ram_ceu_n_o = ce_n[1];
    assign ram_cel_n_o = ce_n[0];

    sram_seq #(
        .RD_LEN  (RD_LEN),
        .WP_LEN  (WP_LEN),
        .GAP_LEN (GAP_LEN)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .wr_i    (wr_i),
        .mask_i  (mask),
        .phase_o (phase),
        .load_o  (load),
        .last_o  (last),
        .done_o  (done_o)
    );

    sram_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk         (clk),
        .rst         (rst),
        .phase_i     (phase),
        .load_i      (load),
        .last_i      (last),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .mask_i      (mask),
        .rdata_o     (rdata_o),
        .ram_addr_o  (ram_addr_o),
        .ram_ce_n_o  (ce_n),
        .ram_we_n_o  (ram_we_n_o),
        .ram_oe_n_o  (ram_oe_n_o),
        .ram_dq_o    (ram_dq_o),
        .ram_dq_oe_o (ram_dq_oe_o),
        .ram_dq_i    (ram_dq_i)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> ram_ceu_n_o && ram_cel_n_o && ram_we_n_o && ram_oe_n_o
                       && (ram_dq_oe_o == 2'b00) && !done_o);

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ram_ceu_n_o && ram_cel_n_o && ram_we_n_o && ram_oe_n_o);

endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int RD_EXP  = 7;
    localparam int WP_EXP  = 6;
    localparam int GAP_EXP = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [16:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  bmask = '0;
    logic        done;
    logic [15:0] rdata;
    logic [16:0] ram_addr;
    logic        ceu_n, cel_n, we_n, oe_n;
    logic [15:0] dq_o;
    logic [1:0]  dq_oe;
    logic [15:0] dq_i = 16'hA5A5;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [15:0] pmem   [int];
    logic [15:0] shadow [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_lane_ctrl u0 (
        .clk(clk), .rst(rst), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .bmask_i(bmask), .done_o(done), .rdata_o(rdata),
        .ram_addr_o(ram_addr), .ram_ceu_n_o(ceu_n), .ram_cel_n_o(cel_n),
        .ram_we_n_o(we_n), .ram_oe_n_o(oe_n), .ram_dq_o(dq_o),
        .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_i)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lmask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    function automatic logic [15:0] mem_rd(input int a);
        if (pmem.exists(a)) return pmem[a];
        return 16'h0000;
    endfunction

    // pin-level RAM model and protocol monitor
    logic        p_we_n = 1'b1, p_oe_n = 1'b1, p_ceu_n = 1'b1, p_cel_n = 1'b1;
    logic [16:0] p_addr = '0;
    logic [15:0] p_dq = '0;
    logic [1:0]  p_dq_oe = '0;
    int          we_run = 0, oe_run = 0;
    bit          ce_seen = 0;

    always @(negedge clk) begin
        if (!rst) begin
            logic act_now, act_prev;
            act_now  = !ceu_n || !cel_n || !we_n || !oe_n;
            act_prev = !p_ceu_n || !p_cel_n || !p_we_n || !p_oe_n;
            if (!ceu_n || !cel_n) ce_seen = 1;
            if ((dq_oe != 2'b00) && (!oe_n || we_n))
                check(0, "R4 drive outside write", {dq_oe, oe_n, we_n}, 32'h1);
            if ((dq_oe[1] && ceu_n) || (dq_oe[0] && cel_n))
                check(0, "R4 drive on disabled lane", {dq_oe, ceu_n, cel_n}, 32'h0);
            if (!we_n && !oe_n)
                check(0, "R3 oe low during write", 32'h0, 32'h1);
            if ((!ceu_n || !cel_n) && (!p_ceu_n || !p_cel_n) && ram_addr != p_addr)
                check(0, "R5 address moved", ram_addr, p_addr);
            if (done)
                check(!act_now && !act_prev, "R6 controls active near done",
                      {act_now, act_prev}, 32'h0);
            if (!we_n) we_run++;
            else if (!p_we_n) begin
                logic [15:0] w;
                check(we_run == WP_EXP, "R3 write pulse width", we_run, WP_EXP);
                w = mem_rd(int'(p_addr));
                if (!p_ceu_n && p_dq_oe[1]) w[15:8] = p_dq[15:8];
                if (!p_cel_n && p_dq_oe[0]) w[7:0]  = p_dq[7:0];
                pmem[int'(p_addr)] = w;
                we_run = 0;
            end
            if (!oe_n) oe_run++;
            else if (!p_oe_n) begin
                check(oe_run == RD_EXP, "R2 read window width", oe_run, RD_EXP);
                oe_run = 0;
            end
            if (!oe_n && we_n) begin
                logic [15:0] r;
                r = mem_rd(int'(ram_addr));
                dq_i = {ceu_n ? 8'hA5 : r[15:8], cel_n ? 8'h5A : r[7:0]};
            end else begin
                dq_i = 16'hA5A5;
            end
        end
        p_we_n = we_n; p_oe_n = oe_n; p_ceu_n = ceu_n; p_cel_n = cel_n;
        p_addr = ram_addr; p_dq = dq_o; p_dq_oe = dq_oe;
    end

    task automatic do_op(input bit w, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] m, output logic [15:0] rd, output int lat);
        @(negedge clk);
        req = 1'b1; wr = w; addr = a; wdata = d; bmask = m;
        ce_seen = 0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!done && lat < 100);
        rd = rdata;
        req = 1'b0;
        if (!done) check(0, "R7 no done", lat, 0);
    endtask

    task automatic wr_op(input logic [16:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] rd;
        int lat;
        do_op(1'b1, a, d, m, rd, lat);
        if (m == 2'b00) begin
            check(lat == GAP_EXP + 1, "R8 empty write latency", lat, GAP_EXP + 1);
            check(!ce_seen, "R8 enable asserted for empty mask", ce_seen, 0);
        end else begin
            check(lat == WP_EXP + GAP_EXP + 1, "R7 write latency", lat, WP_EXP + GAP_EXP + 1);
        end
        shadow[int'(a)] = (shadow[int'(a)] & ~lmask(m)) | (d & lmask(m));
    endtask

    task automatic rd_op(input logic [16:0] a, input logic [1:0] m);
        logic [15:0] rd, exp;
        int lat;
        do_op(1'b0, a, 16'hFFFF, m, rd, lat);
        exp = shadow[int'(a)] & lmask(m);
        if (m == 2'b00) begin
            check(lat == GAP_EXP + 1, "R8 empty read latency", lat, GAP_EXP + 1);
            check(rd == 16'h0, "R8 empty read data", rd, 0);
        end else begin
            check(lat == RD_EXP + GAP_EXP + 1, "R7 read latency", lat, RD_EXP + GAP_EXP + 1);
            check(rd == exp, "R2 read data", rd, exp);
        end
        @(negedge clk);
        check(rdata == rd, "R9 read data held", rdata, rd);
    endtask

    initial begin
        logic [16:0] alist [6];
        alist[0] = 17'h00000; alist[1] = 17'h00001; alist[2] = 17'h1FFFF;
        alist[3] = 17'h0AAAA; alist[4] = 17'h15555; alist[5] = 17'h10000;
        repeat (3) @(negedge clk);
        check(ceu_n && cel_n && we_n && oe_n, "R1 controls in reset",
              {ceu_n, cel_n, we_n, oe_n}, 4'hF);
        check(dq_oe == 2'b00 && !done && rdata == 0, "R1 outputs in reset",
              {dq_oe, done, rdata}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ceu_n && cel_n && we_n && oe_n && dq_oe == 0 && !done,
              "R1 idle after reset", {ceu_n, cel_n, we_n, oe_n, dq_oe, done}, 6'h3C);
        for (int i = 0; i < 6; i++) begin
            shadow[int'(alist[i])] = 16'h0000;
            wr_op(alist[i], {alist[i][7:0] ^ 8'h3C, alist[i][15:8] + 8'h11}, 2'b11);
        end
        for (int i = 0; i < 6; i++) begin
            for (int m = 0; m < 4; m++) begin
                wr_op(alist[i], 16'(alist[i] * 7 + m * 16'h1357 + 16'h0F0F), 2'(m));
                for (int r = 0; r < 4; r++) rd_op(alist[i], 2'(r));
            end
        end
        // R9: read data clears when the next request is accepted
        rd_op(alist[2], 2'b11);
        @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = alist[3]; wdata = 16'h1234; bmask = 2'b00;
        @(negedge clk);
        check(rdata == 16'h0, "R9 clear on accept", rdata, 0);
        while (!done) @(negedge clk);
        req = 1'b0;
        rd_op(alist[3], 2'b11);
        finished = 1;
    end

    initial begin
        int n = 0;
        while (!finished && n < 150000) begin
            @(negedge clk);
            n++;
        end
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=done", n);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule